// File: doc/BRIEF.md
# Hit Count and Data Packer

After an event has been accepted for readout, this block walks every input channel of a time digitiser and packs the hit results into two write-only readout buffers. One is a short table of 4-bit per-channel count fields, which starts with a header word that carries an event sequence number. The other is a variable-length list of 16-bit hits, two to a 32-bit word. The hit-data buffer is never cleared. When packing ends, the block reports the number of hit-data words written for this event, and a downstream block-transfer controller reads that many words.

The per-channel results come through a lookup port. The packer drives a channel index and a hit index. The surrounding logic returns, in the same cycle, that channel's hit count, its enable status and the addressed hit pair (leading edge in the upper byte, width in the lower byte). A one-cycle `start` pulse begins an event. `done` pulses once with `wordCount` valid.

Top module: `hitPacker`

## Requirements
- R1: After reset, `busy`, `done`, `cntWe` and `datWe` are 0 and `wordCount` is 0.
- R2: An accepted `start` writes count-buffer address 0 with the event sequence number, zero-extended. The number is 1 for the first event after reset and grows by one for each accepted start. A `start` that arrives while `busy` is high is ignored.
- R3: Channel c's count field sits at count-buffer address 1 + c/8, bits [4*(c%8)+3 : 4*(c%8)]. Bit 3 of the field is the enable status and bits 2:0 are the hit count (0 to 7). Each count-buffer word is written exactly once per event.
- R4: A disabled channel (`chanOn` = 0) reports field 4'b0000 and contributes no hit pairs, whatever count and pair values it presents.
- R5: Hit pairs are written in ascending channel order, and within a channel in hit index order 0 .. count-1. They go to hit-data addresses 0, 1, 2 ... in turn. The earlier pair of each word goes in bits 31:16 and the later pair in bits 15:0.
- R6: When the total number of hits is odd, bits 15:0 of the last hit-data word are zero.
- R7: At the end of an event `done` is high for exactly one cycle, and `wordCount` = ceil(total hits / 2). `wordCount` keeps that value until the next event ends.
- R8: Each event writes every hit-data address below `wordCount` exactly once and writes no address at or above it. A full event (48 channels × 7 hits) gives 168 words.
- R9: An event with no hits writes no hit-data word and reports `wordCount` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins packing an event |
| chanSel | output | CH_W (6) | Channel index presented to the lookup port |
| hitSel | output | 3 | Hit index within the selected channel |
| chanHits | input | 3 | Hit count of the selected channel |
| chanOn | input | 1 | Enable status of the selected channel |
| hitPair | input | 16 | Selected hit: leading edge [15:8], width [7:0] |
| cntWe | output | 1 | Count-buffer write strobe |
| cntAddr | output | CNT_AW (3) | Count-buffer write address |
| cntData | output | 32 | Count-buffer write data |
| datWe | output | 1 | Hit-data buffer write strobe |
| datAddr | output | DAT_AW (8) | Hit-data buffer write address |
| datData | output | 32 | Hit-data buffer write data |
| busy | output | 1 | High while an event is being packed |
| done | output | 1 | One-cycle end-of-event pulse |
| wordCount | output | DAT_AW (8) | Hit-data words written by the last event |

## Verification
The hardest case to reach from the ports is a `start` that arrives while the packer is still walking the channels, because it only matters if it silently bumps the sequence number or restarts the scan. The bench injects such a pulse a few cycles into one event and then checks the next header. Odd and even totals, fully disabled channels that still present nonzero counts, the full 168-word event and the empty event are forced by directed events. Seeded random events mix these conditions with varied counts and masks.

// File: rtl/hitPackPkg.sv
package hitPackPkg;
  localparam int PAIR_W  = 16;
  localparam int HIT_W   = 3;
  localparam int HIT_MAX = 7;
  localparam int NIB_PER_WORD = 8;

  typedef struct packed {
    logic       hdr;       // open event, emit header
    logic       push;      // append current hit pair
    logic       close;     // merge current channel field
    logic       closeWord; // write the assembled count word
    logic [2:0] slot;      // field position inside the count word
    logic       fin;       // flush pending half word, report count
  } packStrobe_t;
endpackage

// File: rtl/packCtrl.sv
module packCtrl
  import hitPackPkg::*;
#(
  parameter int NUM_CH = 48,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [HIT_W-1:0]    chanHits,
  input  logic                chanOn,
  output logic [CH_W-1:0]     chanSel,
  output logic [HIT_W-1:0]    hitSel,
  output packStrobe_t         strb,
  output logic                busy
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FIN} state_t;
  state_t state;
  logic [CH_W-1:0]  chanIdx;
  logic [HIT_W-1:0] hitIdx;
  logic [HIT_W-1:0] effCnt;
  logic             lastChan;

  assign effCnt   = chanOn ? chanHits : '0;
  assign lastChan = (chanIdx == CH_W'(NUM_CH - 1));
  assign chanSel  = chanIdx;
  assign hitSel   = hitIdx;
  assign busy     = (state != S_IDLE);

  always_comb begin
    strb      = '0;
    strb.slot = chanIdx[2:0];
    unique case (state)
      S_IDLE: strb.hdr = start;
      S_SCAN: begin
        if (hitIdx < effCnt) strb.push = 1'b1;
        else begin
          strb.close     = 1'b1;
          strb.closeWord = (chanIdx[2:0] == 3'd7) || lastChan;
        end
      end
      S_FIN:  strb.fin = 1'b1;
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      chanIdx <= '0;
      hitIdx  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_SCAN;
          chanIdx <= '0;
          hitIdx  <= '0;
        end
        S_SCAN: begin
          if (strb.push) hitIdx <= hitIdx + 3'd1;
          else begin
            hitIdx <= '0;
            if (lastChan) state <= S_FIN;
            else chanIdx <= chanIdx + 1'b1;
          end
        end
        S_FIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: a disabled channel never contributes a hit pair
  p_masked_nopush_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> chanOn);
  // R5: hits are taken only below the presented count
  p_hit_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (hitIdx < chanHits));
  // R3: the scan ends only after the last channel was closed
  p_scan_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SCAN && strb.close && lastChan) |=> (state == S_FIN));
endmodule

// File: rtl/packData.sv
module packData
  import hitPackPkg::*;
#(
  parameter int NUM_CH = 48,
  parameter int SEQ_W  = 16,
  localparam int CNT_WORDS = (NUM_CH + NIB_PER_WORD - 1) / NIB_PER_WORD + 1,
  localparam int CNT_AW    = $clog2(CNT_WORDS),
  localparam int MAX_WORDS = (NUM_CH * HIT_MAX + 1) / 2,
  localparam int DAT_AW    = $clog2(MAX_WORDS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  packStrobe_t         strb,
  input  logic [HIT_W-1:0]    chanHits,
  input  logic                chanOn,
  input  logic [PAIR_W-1:0]   hitPair,
  output logic                cntWe,
  output logic [CNT_AW-1:0]   cntAddr,
  output logic [31:0]         cntData,
  output logic                datWe,
  output logic [DAT_AW-1:0]   datAddr,
  output logic [31:0]         datData,
  output logic                done,
  output logic [DAT_AW-1:0]   wordCount
);
  logic [SEQ_W-1:0]  seqNum;
  logic [31:0]       nibAcc;
  logic [31:0]       merged;
  logic [3:0]        nib;
  logic [PAIR_W-1:0] halfHold;
  logic              halfFull;
  logic [CNT_AW-1:0] cntPtr;
  logic [DAT_AW-1:0] datPtr;

  assign nib = {chanOn, chanOn ? chanHits : 3'b000};

  always_comb begin
    merged = nibAcc;
    merged[4*strb.slot +: 4] = nib;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqNum    <= '0;
      nibAcc    <= '0;
      halfHold  <= '0;
      halfFull  <= 1'b0;
      cntPtr    <= '0;
      datPtr    <= '0;
      cntWe     <= 1'b0;
      cntAddr   <= '0;
      cntData   <= '0;
      datWe     <= 1'b0;
      datAddr   <= '0;
      datData   <= '0;
      done      <= 1'b0;
      wordCount <= '0;
    end else begin
      cntWe <= 1'b0;
      datWe <= 1'b0;
      done  <= 1'b0;
      if (strb.hdr) begin
        seqNum   <= seqNum + 1'b1;
        cntWe    <= 1'b1;
        cntAddr  <= '0;
        cntData  <= {{(32-SEQ_W){1'b0}}, seqNum + 1'b1};
        cntPtr   <= CNT_AW'(1);
        datPtr   <= '0;
        nibAcc   <= '0;
        halfFull <= 1'b0;
      end
      if (strb.push) begin
        if (!halfFull) begin
          halfHold <= hitPair;
          halfFull <= 1'b1;
        end else begin
          datWe    <= 1'b1;
          datAddr  <= datPtr;
          datData  <= {halfHold, hitPair};
          datPtr   <= datPtr + 1'b1;
          halfFull <= 1'b0;
        end
      end
      if (strb.close) begin
        if (strb.closeWord) begin
          cntWe   <= 1'b1;
          cntAddr <= cntPtr;
          cntData <= merged;
          cntPtr  <= cntPtr + 1'b1;
          nibAcc  <= '0;
        end else begin
          nibAcc <= merged;
        end
      end
      if (strb.fin) begin
        done <= 1'b1;
        if (halfFull) begin
          datWe     <= 1'b1;
          datAddr   <= datPtr;
          datData   <= {halfHold, {PAIR_W{1'b0}}};
          wordCount <= datPtr + 1'b1;
          halfFull  <= 1'b0;
        end else begin
          wordCount <= datPtr;
        end
      end
    end
  end

  // R2: each accepted event advances the sequence number by exactly one
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.hdr |=> (seqNum == $past(seqNum) + 1'b1));
  // R7: the end-of-event strobe lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: no hit-data write beyond the largest possible event
  p_dat_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    datWe |-> (datAddr < DAT_AW'(MAX_WORDS)));
  // R7: the reported count never exceeds the full-event size
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (wordCount <= DAT_AW'(MAX_WORDS)));
  // R3: count-table writes stay inside the table
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |-> (cntAddr < CNT_AW'(CNT_WORDS)));
endmodule

// File: rtl/hitPacker.sv
module hitPacker
  import hitPackPkg::*;
#(
  parameter int NUM_CH = 48,
  parameter int SEQ_W  = 16,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int CNT_WORDS = (NUM_CH + NIB_PER_WORD - 1) / NIB_PER_WORD + 1,
  localparam int CNT_AW    = $clog2(CNT_WORDS),
  localparam int MAX_WORDS = (NUM_CH * HIT_MAX + 1) / 2,
  localparam int DAT_AW    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [CH_W-1:0]   chanSel,
  output logic [2:0]        hitSel,
  input  logic [2:0]        chanHits,
  input  logic              chanOn,
  input  logic [15:0]       hitPair,
  output logic              cntWe,
  output logic [CNT_AW-1:0] cntAddr,
  output logic [31:0]       cntData,
  output logic              datWe,
  output logic [DAT_AW-1:0] datAddr,
  output logic [31:0]       datData,
  output logic              busy,
  output logic              done,
  output logic [DAT_AW-1:0] wordCount
);
  packStrobe_t strb;

  packCtrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .chanHits(chanHits), .chanOn(chanOn),
    .chanSel(chanSel), .hitSel(hitSel), .strb(strb), .busy(busy)
  );

  packData #(.NUM_CH(NUM_CH), .SEQ_W(SEQ_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .chanHits(chanHits), .chanOn(chanOn), .hitPair(hitPair),
    .cntWe(cntWe), .cntAddr(cntAddr), .cntData(cntData),
    .datWe(datWe), .datAddr(datAddr), .datData(datData),
    .done(done), .wordCount(wordCount)
  );
endmodule

// File: tb/test_hitPacker.sv
`timescale 1ns/1ps
module test_hitPacker;
  localparam int NCH = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [5:0]  chanSel;
  logic [2:0]  hitSel;
  logic [2:0]  chanHits;
  logic        chanOn;
  logic [15:0] hitPair;
  logic        cntWe, datWe, busy, done;
  logic [2:0]  cntAddr;
  logic [7:0]  datAddr, wordCount;
  logic [31:0] cntData, datData;

  always #2 clk = ~clk;

  hitPacker i_hitPacker (
    .clk(clk), .rstN(rstN), .start(start),
    .chanSel(chanSel), .hitSel(hitSel), .chanHits(chanHits), .chanOn(chanOn),
    .hitPair(hitPair), .cntWe(cntWe), .cntAddr(cntAddr), .cntData(cntData),
    .datWe(datWe), .datAddr(datAddr), .datData(datData),
    .busy(busy), .done(done), .wordCount(wordCount)
  );

  logic [2:0]  cntArr  [NCH];
  logic        enArr   [NCH];
  logic [15:0] pairArr [NCH][8];

  always_comb begin
    chanHits = (chanSel < NCH) ? cntArr[chanSel] : 3'd0;
    chanOn   = (chanSel < NCH) ? enArr[chanSel]  : 1'b0;
    hitPair  = (chanSel < NCH) ? pairArr[chanSel][hitSel] : 16'h0;
  end

  logic [31:0] cntMem [8];
  int          cntWrites [8];
  logic [31:0] datMem [256];
  int          datWrites [256];
  int          highWrites;
  int nChecks = 0;
  int nFails  = 0;
  int expSeq  = 0;

  always @(negedge clk) begin
    if (cntWe) begin cntMem[cntAddr] = cntData; cntWrites[cntAddr]++; end
    if (datWe) begin datMem[datAddr] = datData; datWrites[datAddr]++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] fieldOf(input int c);
    return enArr[c] ? {1'b1, cntArr[c]} : 4'b0000;
  endfunction

  function automatic int totalHits();
    int n = 0;
    for (int c = 0; c < NCH; c++) if (enArr[c]) n += cntArr[c];
    return n;
  endfunction

  function automatic logic [15:0] nthPair(input int k);
    int n = 0;
    for (int c = 0; c < NCH; c++)
      if (enArr[c])
        for (int h = 0; h < cntArr[c]; h++) begin
          if (n == k) return pairArr[c][h];
          n++;
        end
    return 16'h0;
  endfunction

  task automatic fillRandom(input int enPct);
    for (int c = 0; c < NCH; c++) begin
      cntArr[c] = 3'($urandom_range(0, 7));
      enArr[c]  = ($urandom_range(0, 99) < enPct);
      for (int h = 0; h < 8; h++) pairArr[c][h] = 16'($urandom);
    end
  endtask

  // Runs one event; lateStart injects a start pulse while busy.
  task automatic runEvent(input string tag, input bit lateStart);
    int tot, expWc, waited;
    logic [31:0] expWord;
    for (int i = 0; i < 8; i++) begin cntMem[i] = 32'hDEAD0000; cntWrites[i] = 0; end
    for (int i = 0; i < 256; i++) datWrites[i] = 0;
    tot = totalHits();
    expWc = (tot + 1) / 2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    expSeq++;
    if (lateStart) begin
      repeat (4) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 2000) begin @(negedge clk); waited++; end
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL R7 %s: done never rose actual=0 expected=1", tag);
      return;
    end
    chk($sformatf("R7 %s wordCount", tag), 32'(wordCount), 32'(expWc));
    if (tot == 0) chk($sformatf("R9 %s empty count", tag), 32'(wordCount), 32'd0);
    @(negedge clk);
    chk($sformatf("R7 %s done one cycle", tag), 32'(done), 32'd0);
    chk($sformatf("R2 %s header", tag), cntMem[0], 32'(expSeq));
    for (int w = 1; w < 7; w++) begin
      expWord = '0;
      for (int j = 0; j < 8; j++) expWord[4*j +: 4] = fieldOf(8*(w-1) + j);
      chk($sformatf("R3 R4 %s count word %0d", tag, w), cntMem[w], expWord);
    end
    for (int w = 0; w < 7; w++)
      chk($sformatf("R3 %s count word %0d write once", tag, w), 32'(cntWrites[w]), 32'd1);
    for (int w = 0; w < expWc; w++) begin
      expWord[31:16] = nthPair(2*w);
      expWord[15:0]  = (2*w + 1 < tot) ? nthPair(2*w + 1) : 16'h0;
      chk($sformatf("R5 R6 %s data word %0d", tag, w), datMem[w], expWord);
      chk($sformatf("R8 %s data word %0d write once", tag, w), 32'(datWrites[w]), 32'd1);
    end
    highWrites = 0;
    for (int w = expWc; w < 256; w++) highWrites += datWrites[w];
    chk($sformatf("R8 %s no write above count", tag), 32'(highWrites), 32'd0);
    repeat (3) @(negedge clk);
    chk($sformatf("R7 %s count held", tag), 32'(wordCount), 32'(expWc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog R7: run hung actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) begin
      cntArr[c] = 3'd0; enArr[c] = 1'b1;
      for (int h = 0; h < 8; h++) pairArr[c][h] = 16'h0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 wordCount", 32'(wordCount), 32'd0);
    chk("R1 write strobes", {30'd0, cntWe, datWe}, 32'd0);

    // R9: all enabled, no hits
    runEvent("empty", 1'b0);

    // R4: every channel disabled but presenting full counts
    for (int c = 0; c < NCH; c++) begin
      cntArr[c] = 3'd7; enArr[c] = 1'b0;
      for (int h = 0; h < 8; h++) pairArr[c][h] = 16'hA5A5 ^ 16'(c*8+h);
    end
    runEvent("allMasked", 1'b0);

    // R8: full event, 168 words
    for (int c = 0; c < NCH; c++) enArr[c] = 1'b1;
    runEvent("full", 1'b0);

    // R6: a single hit on the last channel
    for (int c = 0; c < NCH; c++) cntArr[c] = 3'd0;
    cntArr[NCH-1] = 3'd1;
    runEvent("oneHit", 1'b0);

    // R2: start while busy must be ignored
    fillRandom(75);
    runEvent("lateStart", 1'b1);
    fillRandom(75);
    runEvent("afterLate", 1'b0);

    for (int e = 0; e < 20; e++) begin
      fillRandom(e % 2 ? 90 : 50);
      runEvent($sformatf("rand%0d", e), 1'b0);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule